// File: doc/BRIEF.md
# Sequencer State-Word Fetch Engine

This block keeps exactly one state definition of a supply-sequencing engine resident. Each definition is a 64-bit word held in a dedicated nonvolatile store of 512 bytes, with one word per slot and 64 slots. The store is reached through a byte-wide read port. Slot 63 is reserved and is never made active, so 63 slots are usable. After reset the engine fetches slot 0. The sequencing logic that reads the active word pulses a condition-met input. On that pulse the engine takes the index of the next slot from the low six bits of the active word and fetches that slot.

There is no RAM image of the state table. Every transition reads the nonvolatile word again. An edit made to the store therefore shows up the next time its slot is entered. Each fetch takes a fixed, parameterised number of cycles. The default of 500 cycles is about 10 µs at 50 MHz. A busy flag is held for the whole fetch.

Top module: `seq_word_fetch`

## Requirements
- R1: While reset is asserted, busy is 1, state_valid is 0 and bad_jump is 0. When reset is released, a fetch of slot 0 proceeds without any other stimulus, and at its end state_idx is 0.
- R2: A fetch of slot i asserts mem_rd in the first 8 cycles of the fetch, one read per cycle. The addresses are i*8+0 up to i*8+7 in ascending order, so mem_addr is {slot, byte}. The store answers one cycle after each read.
- R3: The byte that the store returns for address i*8+k is placed in bits [8k+7:8k] of state_word, so the least significant byte comes first.
- R4: After an accepted condition-met pulse, busy is 1 for exactly LOAD_CYCLES cycles. While busy is 1, state_valid is 0. When busy falls, state_valid rises and state_word holds the new word.
- R5: A condition-met pulse is accepted when busy is 0 and state_valid is 1. It then starts a fetch of the slot named by state_word[5:0], and state_idx takes that value.
- R6: If state_word[5:0] is 63, the reserved slot, a condition-met pulse starts no fetch. mem_rd stays 0, busy stays 0, and state_idx and state_word are unchanged. bad_jump becomes 1 and stays 1 until reset.
- R7: A condition-met pulse that arrives while busy is 1 has no effect. The slot that is loaded and the length of the fetch are unchanged.
- R8: The engine keeps no copy of the table. If a slot is entered again after its bytes in the store were changed, the changed bytes appear in state_word.
- R9: While busy is 0, state_word and state_idx do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_met | input | 1 | Exit condition of the active state is met |
| mem_rd | output | 1 | Byte read strobe to the store |
| mem_addr | output | 9 | Byte address {slot, byte} |
| mem_data | input | 8 | Byte returned by the store one cycle after mem_rd |
| state_word | output | 64 | Active state definition |
| state_valid | output | 1 | state_word holds a completely loaded state |
| state_idx | output | 6 | Slot of the active state |
| busy | output | 1 | A fetch is in progress |
| bad_jump | output | 1 | Sticky: a jump to the reserved slot was requested |

## Verification
The case that is hardest to reach is a jump to the reserved slot. It needs an active word whose next field is 63, and that word can only come from the store through an ordinary fetch. The bench runs the engine through a chain of slots. It then rewrites the bytes of slot 0, including a next field of 63, and re-enters slot 0. This one step shows that the table is read again on every transition, and it leaves the engine ready for the refused jump. During every fetch a second condition-met pulse is injected to show that it is ignored.

// File: rtl/seq_word_fetch.sv
module seq_word_fetch #(
  parameter int IDX_W        = 6,
  parameter int WORD_BYTES   = 8,
  parameter int LOAD_CYCLES  = 500,
  parameter int RESERVED_IDX = 63,
  parameter int NEXT_LSB     = 0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cond_met,
  output logic                          mem_rd,
  output logic [IDX_W+$clog2(WORD_BYTES)-1:0] mem_addr,
  input  logic [7:0]                    mem_data,
  output logic [8*WORD_BYTES-1:0]       state_word,
  output logic                          state_valid,
  output logic [IDX_W-1:0]              state_idx,
  output logic                          busy,
  output logic                          bad_jump
);
  // LOAD_CYCLES must exceed WORD_BYTES + 1 so the last byte lands before commit
  localparam int WORD_W = 8 * WORD_BYTES;
  localparam int BSEL_W = $clog2(WORD_BYTES);
  localparam int CNT_W  = $clog2(LOAD_CYCLES + 1);

  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shadow;
  logic              rd_q;
  logic [BSEL_W-1:0] sel_q;

  wire [IDX_W-1:0] next_idx    = state_word[NEXT_LSB +: IDX_W];
  wire             take        = cond_met && !busy && state_valid;
  wire             to_reserved = (next_idx == IDX_W'(RESERVED_IDX));

  assign mem_rd   = busy && (cnt < CNT_W'(WORD_BYTES));
  assign mem_addr = {state_idx, cnt[BSEL_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      sel_q  <= '0;
      shadow <= '0;
    end else begin
      rd_q  <= mem_rd;
      sel_q <= cnt[BSEL_W-1:0];
      if (rd_q) shadow[{sel_q, 3'b000} +: 8] <= mem_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b1;
      cnt         <= '0;
      state_idx   <= '0;
      state_valid <= 1'b0;
      state_word  <= '0;
      bad_jump    <= 1'b0;
    end else if (busy) begin
      if (cnt == CNT_W'(LOAD_CYCLES - 1)) begin
        busy        <= 1'b0;
        state_valid <= 1'b1;
        state_word  <= shadow;
        cnt         <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (take) begin
      if (to_reserved) begin
        bad_jump <= 1'b1;
      end else begin
        state_idx   <= next_idx;
        busy        <= 1'b1;
        state_valid <= 1'b0;
        cnt         <= '0;
      end
    end
  end
endmodule

// File: rtl/seq_word_fetch_chk.sv
module seq_word_fetch_chk #(
  parameter int IDX_W        = 6,
  parameter int WORD_W       = 64,
  parameter int LOAD_CYCLES  = 500,
  parameter int RESERVED_IDX = 63
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              state_valid,
  input logic [IDX_W-1:0]  state_idx,
  input logic [WORD_W-1:0] state_word,
  input logic              bad_jump
);
  logic [31:0] busy_len;
  always_ff @(posedge clk) begin
    if (!rst_n) busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1;
    else busy_len <= '0;
  end

  // R4
  fetch_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == 32'(LOAD_CYCLES));
  // R4
  valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !state_valid);
  // R6
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_jump |=> bad_jump);
  // R6
  no_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_valid |-> state_idx != IDX_W'(RESERVED_IDX));
  // R7
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(state_idx));
  // R9
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(state_word));
endmodule

bind seq_word_fetch seq_word_fetch_chk #(
  .IDX_W(IDX_W), .WORD_W(8*WORD_BYTES),
  .LOAD_CYCLES(LOAD_CYCLES), .RESERVED_IDX(RESERVED_IDX)
) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .state_valid(state_valid),
  .state_idx(state_idx), .state_word(state_word), .bad_jump(bad_jump)
);

// File: tb/seq_word_fetch_tb_top.sv
`timescale 1ns/1ps
module seq_word_fetch_tb_top;
  localparam int L = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cond_met = 1'b0;
  logic        mem_rd;
  logic [8:0]  mem_addr;
  logic [7:0]  mem_data = 8'h00;
  logic [63:0] state_word;
  logic        state_valid;
  logic [5:0]  state_idx;
  logic        busy;
  logic        bad_jump;

  always #10 clk = ~clk;

  seq_word_fetch #(.LOAD_CYCLES(L)) dut_i (
    .clk(clk), .rst_n(rst_n), .cond_met(cond_met), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_data(mem_data), .state_word(state_word),
    .state_valid(state_valid), .state_idx(state_idx), .busy(busy),
    .bad_jump(bad_jump)
  );

  logic [7:0] mem [0:511];
  always_ff @(posedge clk) if (mem_rd) mem_data <= mem[mem_addr];

  int n_rd;
  logic [8:0] rd_log [0:15];
  always @(negedge clk) if (mem_rd) begin
    if (n_rd < 16) rd_log[n_rd] = mem_addr;
    n_rd = n_rd + 1;
  end

  int nvec = 0;
  int nbad = 0;

  localparam logic [5:0] SEQ [0:6] = '{6'd0, 6'd5, 6'd12, 6'd40, 6'd62, 6'd1, 6'd0};

  function automatic logic [63:0] exp_word(input int i);
    logic [63:0] w;
    for (int b = 0; b < 8; b++) w[8*b +: 8] = mem[i*8+b];
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_reads(input int slot);
    bit ok;
    ok = (n_rd == 8);
    for (int k = 0; k < 8; k++) if (n_rd > k && rd_log[k] != 9'(slot*8+k)) ok = 0;
    chk(ok, "R2 read count/order", 64'(n_rd), 64'd8);
  endtask

  task automatic step(input int slot);
    int n;
    n_rd = 0;
    @(negedge clk) cond_met = 1'b1;
    @(negedge clk) cond_met = 1'b0;
    n = 0;
    while (busy && n < 1000) begin
      chk(!state_valid, "R4 valid low while busy", 64'(state_valid), 64'd0);
      n++;
      cond_met = (n == 3);
      @(negedge clk);
    end
    cond_met = 1'b0;
    chk(n == L, "R4/R7 busy length", 64'(n), 64'(L));
    chk(state_valid, "R4 valid after fetch", 64'(state_valid), 64'd1);
    chk(state_idx == 6'(slot), "R5/R7 slot index", 64'(state_idx), 64'(slot));
    chk(state_word == exp_word(slot), "R3 assembled word", state_word, exp_word(slot));
    chk_reads(slot);
  endtask

  task automatic do_reset();
    int n;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy && !state_valid && !bad_jump, "R1 reset state",
        {61'd0, busy, state_valid, bad_jump}, 64'h4);
    n_rd = 0;
    rst_n = 1'b1;
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk(state_valid && state_idx == 6'd0, "R1 slot 0 loaded", 64'(state_idx), 64'd0);
    chk(state_word == exp_word(0), "R1/R3 initial word", state_word, exp_word(0));
    chk_reads(0);
  endtask

  initial begin
    #4_000_000;
    nbad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [63:0] held;
    for (int i = 0; i < 64; i++)
      for (int b = 0; b < 8; b++) mem[i*8+b] = 8'(i*37 + b*11 + 5);
    for (int k = 0; k < 6; k++) mem[SEQ[k]*8] = {2'b10, SEQ[k+1]};
    n_rd = 0;

    do_reset();

    for (int k = 1; k < 7; k++) begin
      if (k == 6) begin
        for (int b = 1; b < 8; b++) mem[b] = 8'hA0 + 8'(b);
        mem[0] = {2'b01, 6'd63};
      end
      step(SEQ[k]);
    end
    // R8: slot 0 reloaded with edited bytes
    chk(state_word[63:8] == 56'hA7A6A5A4A3A2A1, "R8 edited word visible",
        {8'h0, state_word[63:8]}, 64'h00A7A6A5A4A3A2A1);

    held = state_word;
    for (int r = 0; r < 2; r++) begin
      n_rd = 0;
      @(negedge clk) cond_met = 1'b1;
      @(negedge clk) cond_met = 1'b0;
      repeat (5) @(negedge clk);
      chk(!busy && n_rd == 0, "R6 no fetch to reserved", 64'(n_rd), 64'd0);
      chk(bad_jump, "R6 sticky error", 64'(bad_jump), 64'd1);
      chk(state_idx == 6'd0 && state_valid, "R6 index kept", 64'(state_idx), 64'd0);
      chk(state_word == held, "R9 word stable while idle", state_word, held);
    end

    do_reset();
    chk(!bad_jump, "R6 error cleared by reset", 64'(bad_jump), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule